// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address sequence for a DRAM burst. When the burst request becomes active (its active level is chosen by a polarity input), the block captures the start column and the configuration inputs. It then presents the start column and moves to the next column on each selected acknowledge transition. Bursts are 2, 4, 8 or 16 locations long.

In wrap mode the column cycles inside the aligned group of the burst length. In linear mode (no-wrap input high) it counts up by one. A linear burst never crosses the top of the column space. With page mode set, reaching that point ends the burst and raises a one-cycle page-miss flag. In zero-wait mode the column counter is frozen, and the column output follows a CPU-supplied column for the whole burst.

The burst ends after the configured number of acknowledges. It also ends at the first acknowledge that arrives after the request has been withdrawn. The configuration is held for the whole burst. The block does not handle row addresses, refresh or strobe timing.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous active-low reset, `col` is 0, `burst_active` is 0 and `page_miss` is 0.
- R2: While idle, a change of the request from inactive to active starts a burst. On the next clock, `burst_active` is 1 and `col` equals `start_col`. The request is active when `burst_req` equals `req_pol` (1 = active high, 0 = active low). A request already held active through reset does not start a burst.
- R3: `len_sel` sets the burst length: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16. `burst_active` clears at the acknowledge that completes that many acknowledges.
- R4: With `nowrap` = 0, each step increments only the low log2(length) bits modulo the length. The upper bits stay unchanged.
- R5: With `nowrap` = 1, each step adds one to the whole column.
- R6: With `nowrap` = 1 and `page_mode` = 1, a step taken at the all-ones column does three things: it drives `page_miss` high for exactly one cycle, clears `burst_active` in that same cycle, and leaves `col` unchanged.
- R7: With `nowrap` = 1 and `page_mode` = 0, a step at the all-ones column leaves `col` at all ones, and the burst continues.
- R8: With `ack_rise` = 1, a step happens on a rising edge of `ack`. With `ack_rise` = 0, a step happens on a falling edge. `col` changes on the clock after the selected edge is sampled and at no other time during a burst.
- R9: With `zero_wait` = 1, `col` equals `cpu_col` while the burst is active. Acknowledges still count toward the burst length.
- R10: If the request is inactive when an acknowledge step occurs, that acknowledge ends the burst.
- R11: `len_sel`, `nowrap`, `page_mode`, `ack_rise` and `zero_wait` are captured at burst start. Changes to them during a burst have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_col | input | COL_W | First column of a burst |
| cpu_col | input | COL_W | CPU-supplied column for zero-wait bursts |
| len_sel | input | 2 | Burst length code |
| nowrap | input | 1 | 1 = linear increment |
| page_mode | input | 1 | 1 = end the burst with a page miss at the column top |
| ack_rise | input | 1 | 1 = step on rising ack, 0 = step on falling ack |
| zero_wait | input | 1 | 1 = column counter frozen, column taken from cpu_col |
| req_pol | input | 1 | Active level of burst_req |
| burst_req | input | 1 | Burst request |
| ack | input | 1 | Acknowledge strobe |
| col | output | COL_W | Current column |
| burst_active | output | 1 | Burst in progress |
| page_miss | output | 1 | One-cycle flag: burst ended at the page boundary |

## Verification
The bench starts a wrap burst with a non-zero offset, because a design that increments the whole column would carry into the upper bits instead of folding back to the group base. It also runs a linear burst across a group boundary, which exposes a design that wraps even in linear mode. At the all-ones column it checks both page-mode settings: with page mode on, a wrong design would wrap to zero or keep the burst running without a page miss; with page mode off, a wrong design would end the burst. The remaining tests cover falling-edge stepping, zero-wait addressing, active-low requests, early ending after the request is withdrawn, and configuration changes in mid-burst. Each of these catches a design that steps on the wrong edge, moves the counter, starts on the wrong level, or follows the live configuration inputs.

// File: rtl/burst_col_pkg.sv
// Shared types and helpers for the burst column sequencer.
// Assumes burst length codes 0..3 map to 2, 4, 8 and 16 locations.
package burst_col_pkg;

    localparam int LEN_SEL_W = 2;
    localparam int CNT_W     = 4;

    typedef struct packed {
        logic [LEN_SEL_W-1:0] len_sel;
        logic                 nowrap;
        logic                 page_mode;
        logic                 ack_rise;
        logic                 zero_wait;
    } burst_cfg_t;

    // Burst length minus one, used as the last acknowledge count
    function automatic logic [CNT_W-1:0] last_count(input logic [LEN_SEL_W-1:0] sel);
        return CNT_W'((2 << sel) - 1);
    endfunction

    // Number of column bits that wrap for a given length code
    function automatic int unsigned wrap_bits(input logic [LEN_SEL_W-1:0] sel);
        return int'(sel) + 1;
    endfunction

endpackage

// File: rtl/ack_edge_det.sv
// Detects the selected transition of the acknowledge strobe.
// Assumes ack is synchronous to clk; reports a one-cycle pulse
// in the cycle where the new level is first seen.
module ack_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    input  logic rise_sel,
    output logic step
);
    logic ack_q;

    // Hold the previous acknowledge level
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack;
    end

    // Choose rising or falling transition
    always_comb begin
        step = rise_sel ? (ack & ~ack_q) : (~ack & ack_q);
    end

endmodule

// File: rtl/col_stepper.sv
// Computes the next column for one burst step.
// Wrap mode folds the low bits inside the aligned group; linear mode adds one.
// Also flags when the current column is the top of the column space.
module col_stepper #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] cur,
    input  logic [1:0]       len_sel,
    input  logic             nowrap,
    output logic [COL_W-1:0] nxt,
    output logic             at_top
);
    import burst_col_pkg::*;

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] plus1;

    // Build the wrap mask and the incremented column
    always_comb begin
        mask  = COL_W'((1 << wrap_bits(len_sel)) - 1);
        plus1 = cur + COL_W'(1);
        if (nowrap) nxt = plus1;
        else        nxt = (cur & ~mask) | (plus1 & mask);
        at_top = &cur;
    end

endmodule

// File: rtl/burst_col_seq.sv
// Burst column address sequencer top.
// Starts a burst when the request becomes active, captures start column and
// configuration, steps the column on the chosen acknowledge transition and ends
// the burst on length, on a withdrawn request, or on a page-boundary miss.
// Assumes all inputs are synchronous to clk.
module burst_col_seq #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] cpu_col,
    input  logic [1:0]       len_sel,
    input  logic             nowrap,
    input  logic             page_mode,
    input  logic             ack_rise,
    input  logic             zero_wait,
    input  logic             req_pol,
    input  logic             burst_req,
    input  logic             ack,
    output logic [COL_W-1:0] col,
    output logic             burst_active,
    output logic             page_miss
);
    import burst_col_pkg::*;

    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] col_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             miss_q;
    logic             req_act;
    logic             req_q;
    logic             step;
    logic [COL_W-1:0] nxt_col;
    logic             at_top;
    logic [COL_W-1:0] hi_mask;

    // Active request after polarity selection
    always_comb req_act = (burst_req == req_pol);

    ack_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack      (ack),
        .rise_sel (cfg_q.ack_rise),
        .step     (step)
    );

    col_stepper #(.COL_W(COL_W)) u_step (
        .cur     (col_q),
        .len_sel (cfg_q.len_sel),
        .nowrap  (cfg_q.nowrap),
        .nxt     (nxt_col),
        .at_top  (at_top)
    );

    // Burst control: start, step, and end conditions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            col_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            miss_q   <= 1'b0;
            req_q    <= 1'b1;
        end else begin
            miss_q <= 1'b0;
            req_q  <= req_act;
            if (!active_q) begin
                if (req_act && !req_q) begin
                    active_q <= 1'b1;
                    col_q    <= start_col;
                    cnt_q    <= '0;
                    cfg_q    <= '{len_sel, nowrap, page_mode, ack_rise, zero_wait};
                end
            end else if (step) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (cnt_q == last_count(cfg_q.len_sel) || !req_act) begin
                    active_q <= 1'b0;
                end else if (cfg_q.zero_wait) begin
                    col_q <= col_q;
                end else if (cfg_q.nowrap && at_top) begin
                    if (cfg_q.page_mode) begin
                        miss_q   <= 1'b1;
                        active_q <= 1'b0;
                    end
                end else begin
                    col_q <= nxt_col;
                end
            end
        end
    end

    // Output column selection
    always_comb begin
        col          = (active_q && cfg_q.zero_wait) ? cpu_col : col_q;
        burst_active = active_q;
        page_miss    = miss_q;
        hi_mask      = ~COL_W'((1 << wrap_bits(cfg_q.len_sel)) - 1);
    end

    p_miss_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q |-> !active_q);

    p_miss_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q |=> !miss_q);

    p_hold_between_acks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !step) |=> $stable(col_q));

    p_upper_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && !cfg_q.nowrap) |->
        ((col_q & hi_mask) == ($past(col_q) & hi_mask)));

    p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && cfg_q.nowrap && (col_q != $past(col_q))) |->
        (col_q == $past(col_q) + COL_W'(1)));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q <= last_count(cfg_q.len_sel)));

    p_cfg_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q)) |-> (cfg_q == $past(cfg_q)));

endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [COL_W-1:0] cpu_col = '0;
    logic [1:0]       len_sel = '0;
    logic             nowrap = 1'b0;
    logic             page_mode = 1'b0;
    logic             ack_rise = 1'b1;
    logic             zero_wait = 1'b0;
    logic             req_pol = 1'b1;
    logic             burst_req = 1'b0;
    logic             ack = 1'b0;
    logic [COL_W-1:0] col;
    logic             burst_active;
    logic             page_miss;

    int n_run = 0;
    int n_fail = 0;

    burst_col_seq #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_col(start_col), .cpu_col(cpu_col),
        .len_sel(len_sel), .nowrap(nowrap), .page_mode(page_mode),
        .ack_rise(ack_rise), .zero_wait(zero_wait), .req_pol(req_pol),
        .burst_req(burst_req), .ack(ack), .col(col),
        .burst_active(burst_active), .page_miss(page_miss)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Begin a burst with the given settings, request active high unless pol=0
    task automatic begin_burst(input logic [COL_W-1:0] sc, input logic [1:0] ls,
                               input logic nw, input logic pm, input logic rise,
                               input logic zw, input logic pol);
        start_col = sc; len_sel = ls; nowrap = nw; page_mode = pm;
        ack_rise = rise; zero_wait = zw; req_pol = pol; burst_req = ~pol;
        ack = rise ? 1'b0 : 1'b1;
        tick(); tick();
        burst_req = pol;
        tick();
    endtask

    task automatic pulse_ack();
        ack = ~ack; tick();
        ack = ~ack; tick();
    endtask

    task automatic finish_burst();
        burst_req = ~req_pol; tick(); tick();
    endtask

    task automatic t_reset();
        check("R1 col", 32'(col), 32'h0);
        check("R1 active", 32'(burst_active), 32'h0);
        check("R1 miss", 32'(page_miss), 32'h0);
    endtask

    task automatic t_wrap4();
        begin_burst(10'h0A6, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R2 start col", 32'(col), 32'h0A6);
        check("R2 active", 32'(burst_active), 32'h1);
        pulse_ack(); check("R4 step1", 32'(col), 32'h0A7);
        pulse_ack(); check("R4 wrap", 32'(col), 32'h0A4);
        pulse_ack(); check("R4 step3", 32'(col), 32'h0A5);
        check("R3 still active", 32'(burst_active), 32'h1);
        pulse_ack(); check("R3 end after 4", 32'(burst_active), 32'h0);
        finish_burst();
    endtask

    task automatic t_wrap16_and_2();
        begin_burst(10'h3FD, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        pulse_ack(); pulse_ack(); pulse_ack();
        check("R4 len16 wrap", 32'(col), 32'h3F0);
        for (int i = 0; i < 12; i++) pulse_ack();
        check("R3 len16 active before last", 32'(burst_active), 32'h1);
        pulse_ack();
        check("R3 len16 end", 32'(burst_active), 32'h0);
        finish_burst();
        begin_burst(10'h101, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        pulse_ack(); check("R4 len2 wrap", 32'(col), 32'h100);
        pulse_ack(); check("R3 len2 end", 32'(burst_active), 32'h0);
        finish_burst();
    endtask

    task automatic t_linear();
        begin_burst(10'h0FE, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        pulse_ack(); check("R5 lin1", 32'(col), 32'h0FF);
        pulse_ack(); check("R5 lin cross group", 32'(col), 32'h100);
        finish_burst(); pulse_ack();
    endtask

    task automatic t_page_miss();
        begin_burst(10'h3FE, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        pulse_ack(); check("R5 to top", 32'(col), 32'h3FF);
        ack = 1'b1; tick();
        check("R6 miss", 32'(page_miss), 32'h1);
        check("R6 active cleared", 32'(burst_active), 32'h0);
        check("R6 col kept", 32'(col), 32'h3FF);
        ack = 1'b0; tick();
        check("R6 miss one cycle", 32'(page_miss), 32'h0);
        finish_burst();
    endtask

    task automatic t_no_page();
        begin_burst(10'h3FF, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        pulse_ack();
        check("R7 col held", 32'(col), 32'h3FF);
        check("R7 still active", 32'(burst_active), 32'h1);
        check("R7 no miss", 32'(page_miss), 32'h0);
        finish_burst(); pulse_ack();
    endtask

    task automatic t_fall();
        begin_burst(10'h020, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        ack = 1'b0; tick();
        check("R8 fall stepped", 32'(col), 32'h021);
        ack = 1'b1; tick(); tick();
        check("R8 rise ignored", 32'(col), 32'h021);
        finish_burst(); ack = 1'b0; tick(); tick();
    endtask

    task automatic t_zero_wait();
        cpu_col = 10'h155;
        begin_burst(10'h011, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R9 cpu col", 32'(col), 32'h155);
        cpu_col = 10'h2AA; pulse_ack();
        check("R9 cpu col follows", 32'(col), 32'h2AA);
        pulse_ack(); pulse_ack(); pulse_ack();
        check("R9 acks counted", 32'(burst_active), 32'h0);
        check("R9 counter frozen", 32'(col), 32'h011);
        finish_burst();
    endtask

    task automatic t_active_low();
        begin_burst(10'h040, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R2 active low start", 32'(burst_active), 32'h1);
        check("R2 active low col", 32'(col), 32'h040);
        finish_burst(); pulse_ack();
        check("R10 low ends", 32'(burst_active), 32'h0);
        req_pol = 1'b1; burst_req = 1'b0; tick(); tick();
    endtask

    task automatic t_early_end();
        begin_burst(10'h080, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        pulse_ack();
        burst_req = 1'b0; tick();
        check("R10 active until ack", 32'(burst_active), 32'h1);
        pulse_ack();
        check("R10 ended early", 32'(burst_active), 32'h0);
        tick();
    endtask

    task automatic t_cfg_held();
        begin_burst(10'h0C6, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        pulse_ack();
        len_sel = 2'd3; nowrap = 1'b1; zero_wait = 1'b1; cpu_col = 10'h3C3;
        pulse_ack();
        check("R11 wrap kept", 32'(col), 32'h0C4);
        pulse_ack(); pulse_ack();
        check("R11 length kept", 32'(burst_active), 32'h0);
        finish_burst();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1; tick();
        t_reset();
        t_wrap4();
        t_wrap16_and_2();
        t_linear();
        t_page_miss();
        t_no_page();
        t_fall();
        t_zero_wait();
        t_active_low();
        t_early_end();
        t_cfg_held();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule